// File: doc/BRIEF.md
# Pseudo-Associative Serial-Probe Cache

This block is a small read/write cache built on one direct-mapped line store. The store is treated as a set of groups, and each group has several candidate slots. A lookup does not compare several ways at once. It probes the candidate slots one per cycle. Each probe computes a slot index by placing the probe number above the low set bits of the address. The lookup stops at the first slot whose valid bit is set and whose stored tag matches. The hit latency therefore depends on which probe found the line, and the response reports how many probes were used.

When every probe misses a read, the block issues one line fetch to memory. It waits for the memory to return the word, installs the word in a victim slot and returns the data. Writes go straight through to memory. A write that hits also updates the cached copy. A write that misses leaves the cache unchanged. Only one request is in flight at a time.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: The probe numbered p for address a reads store location {p, a[SET_W-1:0]}, where SET_W = log2(LINES/PROBES). Groups with different set bits never disturb each other.
- R2: Probes run in the order 0, 1, …, PROBES-1, one per cycle. A hit on probe p raises rsp_valid p+1 cycles after the accepting edge, with rsp_hit=1 and rsp_probes=p+1.
- R3: A read is declared a miss only after all PROBES probes fail. It then issues exactly one memory read (mem_valid=1, mem_write=0) of the request address. After mem_rvalid it responds with rsp_hit=0, rsp_probes=PROBES and rsp_rdata equal to the word memory returned.
- R4: On a read miss, the word is installed in the first invalid candidate slot, in probe order.
- R5: If every candidate slot of the group is valid, a round-robin pointer kept per group chooses the victim. Each pointer starts at 0 after reset and advances by one, wrapping, after each such replacement in its group.
- R6: A write that hits on probe p updates that slot. The response comes p+1 cycles after acceptance with rsp_hit=1 and rsp_rdata equal to the write data. In the same cycle the block issues a memory write (mem_valid=1, mem_write=1) of the address and data.
- R7: A write that misses responds PROBES cycles after acceptance with rsp_hit=0, rsp_probes=PROBES and rsp_rdata equal to the write data. It issues a memory write in the same cycle and allocates no slot.
- R8: req_ready is high only while no request is in progress. It drops on the cycle after a request is accepted.
- R9: After reset all slots are invalid, req_ready=1, rsp_valid=0 and mem_valid=0.
- R10: The stored tag holds every address bit above the set bits. Two addresses that differ in any of those bits never hit on each other's line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 = a probe matched |
| rsp_probes | output | CNT_W | Number of probes used (1..PROBES) |
| rsp_rdata | output | DATA_W | Read data, or the write data for writes |
| mem_valid | output | 1 | One-cycle memory command strobe |
| mem_write | output | 1 | 1 = write-through, 0 = line fetch |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-through data |
| mem_rvalid | input | 1 | Fetched word is present |
| mem_rdata | input | DATA_W | Fetched word |

## Verification
The bench fills one group slot by slot and reads each line back. A wrong index function or probe order shows up as a hit with the wrong probe count or the wrong latency. It then forces replacements in a full group. A pointer that is shared between groups or never advances evicts the wrong line, and a later read misses or hits where the bench expects the opposite. Write hits and misses are mixed with later reads. A design that allocates on a write miss would hit on the following read, and one that drops the write-through would return stale memory data on a later refill. Addresses that differ only in the top bit check that the tag is not truncated.

// File: rtl/pac_pkg.sv
package pac_pkg;
   typedef enum logic [1:0] {
      PAC_IDLE  = 2'd0,
      PAC_PROBE = 2'd1,
      PAC_FILL  = 2'd2
   } pac_state_e;
endpackage

// File: rtl/pac_probe_seq.sv
module pac_probe_seq
   import pac_pkg::*;
#(
   parameter int PROBES = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic                       hit,
   input  logic                       is_write,
   input  logic                       fill_done,
   output pac_state_e                 state,
   output logic [$clog2(PROBES)-1:0]  probe,
   output logic                       last
);
   localparam int PIDX_W = $clog2(PROBES);

   assign last = (probe == PIDX_W'(PROBES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= PAC_IDLE;
         probe <= '0;
      end else begin
         case (state)
            PAC_IDLE: begin
               if (start) begin
                  state <= PAC_PROBE;
                  probe <= '0;
               end
            end
            PAC_PROBE: begin
               if (hit) begin
                  state <= PAC_IDLE;
               end else if (last) begin
                  state <= is_write ? PAC_IDLE : PAC_FILL;
               end else begin
                  probe <= probe + PIDX_W'(1);
               end
            end
            PAC_FILL: begin
               if (fill_done) state <= PAC_IDLE;
            end
            default: state <= PAC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pac_line_store.sv
module pac_line_store #(
   parameter int LINES  = 32,
   parameter int TAG_W  = 13,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [$clog2(LINES)-1:0]  rd_idx,
   output logic                      rd_valid,
   output logic [TAG_W-1:0]          rd_tag,
   output logic [DATA_W-1:0]         rd_data,
   input  logic                      wr_en,
   input  logic [$clog2(LINES)-1:0]  wr_idx,
   input  logic [TAG_W-1:0]          wr_tag,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [LINES-1:0]          valid_vec
);
   logic [LINES-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n)     vld_q <= '0;
      else if (wr_en) vld_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_valid  = vld_q[rd_idx];
   assign rd_tag    = tag_q[rd_idx];
   assign rd_data   = data_q[rd_idx];
   assign valid_vec = vld_q;
endmodule

// File: rtl/pac_victim_sel.sv
module pac_victim_sel #(
   parameter int PROBES = 4,
   parameter int SETS   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(SETS)-1:0]    set_idx,
   input  logic [PROBES-1:0]          cand_valid,
   input  logic                       commit,
   output logic [$clog2(PROBES)-1:0]  victim
);
   localparam int PIDX_W = $clog2(PROBES);

   logic [PIDX_W-1:0] first_inv;
   logic              any_inv;
   logic [PIDX_W-1:0] rr_q [SETS];

   always_comb begin
      first_inv = '0;
      for (int i = PROBES - 1; i >= 0; i--) begin
         if (!cand_valid[i]) first_inv = PIDX_W'(i);
      end
   end

   assign any_inv = ~&cand_valid;
   assign victim  = any_inv ? first_inv : rr_q[set_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      end else if (commit && !any_inv) begin
         rr_q[set_idx] <= rr_q[set_idx] + PIDX_W'(1);
      end
   end
endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache
   import pac_pkg::*;
#(
   parameter int LINES  = 32,
   parameter int PROBES = 4,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int CNT_W  = $clog2(PROBES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [CNT_W-1:0]  rsp_probes,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int SETS   = LINES / PROBES;
   localparam int SET_W  = $clog2(SETS);
   localparam int PIDX_W = $clog2(PROBES);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - SET_W;

   if (PROBES < 2 || (PROBES & (PROBES - 1)) != 0) begin : g_bad_probes
      $error("PROBES must be a power of two, at least 2");
   end
   if (SETS < 2 || (LINES % PROBES) != 0 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two holding at least two groups");
   end
   if (ADDR_W <= SET_W || CNT_W < $clog2(PROBES + 1)) begin : g_bad_width
      $error("address or count width too small");
   end

   pac_state_e        state;
   logic [PIDX_W-1:0] probe;
   logic              last;
   logic              accept;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              write_q;
   logic [SET_W-1:0]  set_q;
   logic [TAG_W-1:0]  tag_q;
   logic [IDX_W-1:0]  rd_idx;
   logic              rd_valid;
   logic [TAG_W-1:0]  rd_tag;
   logic [DATA_W-1:0] rd_data;
   logic              probe_hit;
   logic              fill_done;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_data;
   logic [LINES-1:0]  valid_vec;
   logic [PROBES-1:0] cand_valid;
   logic [PIDX_W-1:0] victim;

   assign req_ready = (state == PAC_IDLE);
   assign accept    = req_valid && req_ready;
   assign set_q     = addr_q[SET_W-1:0];
   assign tag_q     = addr_q[ADDR_W-1:SET_W];
   assign rd_idx    = {probe, set_q};
   assign probe_hit = (state == PAC_PROBE) && rd_valid && (rd_tag == tag_q);
   assign fill_done = (state == PAC_FILL) && mem_rvalid;

   for (genvar p = 0; p < PROBES; p++) begin : g_cand
      assign cand_valid[p] = valid_vec[{PIDX_W'(p), set_q}];
   end

   pac_probe_seq #(.PROBES(PROBES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .hit       (probe_hit),
      .is_write  (write_q),
      .fill_done (fill_done),
      .state     (state),
      .probe     (probe),
      .last      (last)
   );

   assign wr_en   = (probe_hit && write_q) || fill_done;
   assign wr_idx  = (state == PAC_PROBE) ? rd_idx : {victim, set_q};
   assign wr_data = (state == PAC_PROBE) ? wdata_q : mem_rdata;

   pac_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (rd_idx),
      .rd_valid  (rd_valid),
      .rd_tag    (rd_tag),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_tag    (tag_q),
      .wr_data   (wr_data),
      .valid_vec (valid_vec)
   );

   pac_victim_sel #(.PROBES(PROBES), .SETS(SETS)) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_idx    (set_q),
      .cand_valid (cand_valid),
      .commit     (fill_done),
      .victim     (victim)
   );

   always_ff @(posedge clk) begin
      if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         write_q <= req_write;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_probes <= '0;
         rsp_rdata  <= '0;
         mem_valid  <= 1'b0;
         mem_write  <= 1'b0;
         mem_addr   <= '0;
         mem_wdata  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         mem_valid <= 1'b0;
         if (state == PAC_PROBE) begin
            if (probe_hit) begin
               rsp_valid  <= 1'b1;
               rsp_hit    <= 1'b1;
               rsp_probes <= CNT_W'(probe) + CNT_W'(1);
               rsp_rdata  <= write_q ? wdata_q : rd_data;
            end else if (last) begin
               rsp_valid  <= write_q;
               rsp_hit    <= 1'b0;
               rsp_probes <= CNT_W'(PROBES);
               rsp_rdata  <= wdata_q;
            end
            if ((probe_hit || last) && write_q) begin
               mem_valid <= 1'b1;
               mem_write <= 1'b1;
               mem_addr  <= addr_q;
               mem_wdata <= wdata_q;
            end else if (!probe_hit && last) begin
               mem_valid <= 1'b1;
               mem_write <= 1'b0;
               mem_addr  <= addr_q;
            end
         end
         if (fill_done) begin
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b0;
            rsp_probes <= CNT_W'(PROBES);
            rsp_rdata  <= mem_rdata;
         end
      end
   end
endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
   parameter int PROBES = 4,
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [CNT_W-1:0]  rsp_probes,
   input logic              mem_valid,
   input logic              mem_write,
   input logic [ADDR_W-1:0] mem_addr
);
   logic [15:0]       lat;
   logic [ADDR_W-1:0] addr_seen;
   logic              wr_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat       <= '0;
         addr_seen <= '0;
         wr_seen   <= 1'b0;
      end else if (req_valid && req_ready) begin
         lat       <= '0;
         addr_seen <= req_addr;
         wr_seen   <= req_write;
      end else if (!req_ready && lat != 16'hFFFF) begin
         lat <= lat + 16'd1;
      end
   end

   assert_hit_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_hit |-> lat == 16'(rsp_probes));
   assert_probe_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_probes >= CNT_W'(1) && rsp_probes <= CNT_W'(PROBES));
   assert_miss_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_hit |-> rsp_probes == CNT_W'(PROBES));
   assert_fill_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_write |-> !wr_seen && mem_addr == addr_seen && !req_ready);
   assert_fill_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_write |=> !mem_valid);
   assert_write_through_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && wr_seen |-> mem_valid && mem_write && mem_addr == addr_seen);
   assert_write_miss_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && wr_seen && !rsp_hit |-> lat == 16'(PROBES));
   assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready && !rsp_valid);
endmodule

bind pseudo_assoc_cache pac_checker #(.PROBES(PROBES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pac_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_write  (req_write),
   .req_addr   (req_addr),
   .rsp_valid  (rsp_valid),
   .rsp_hit    (rsp_hit),
   .rsp_probes (rsp_probes),
   .mem_valid  (mem_valid),
   .mem_write  (mem_write),
   .mem_addr   (mem_addr)
);

// File: tb/test_pseudo_assoc_cache.sv
module test_pseudo_assoc_cache;
   localparam int LINES = 32, PROBES = 4, ADDR_W = 16, DATA_W = 32, CNT_W = 3;
   localparam int SETS = LINES / PROBES, FILL_LAT = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_ready;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic rsp_valid, rsp_hit, mem_valid, mem_write;
   logic [CNT_W-1:0] rsp_probes;
   logic [DATA_W-1:0] rsp_rdata, mem_wdata;
   logic [ADDR_W-1:0] mem_addr;
   logic mem_rvalid = 1'b0;
   logic [DATA_W-1:0] mem_rdata = '0;

   always #5 clk = ~clk;

   pseudo_assoc_cache #(.LINES(LINES), .PROBES(PROBES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pseudo_assoc_cache (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_probes(rsp_probes), .rsp_rdata(rsp_rdata),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

   int checks = 0, fails = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // reference content
   function automatic logic [31:0] base_word(input logic [15:0] a);
      return {~a, a} ^ 32'h3C5A_0000;
   endfunction
   logic [31:0] ref_mem [int];
   logic [31:0] bus_mem [int];
   logic        mv [LINES];
   logic [12:0] mt [LINES];
   logic [31:0] md [LINES];
   int          rr [SETS];

   typedef struct { bit hit; int probes; logic [31:0] data; int lat; int acc; } exp_t;
   exp_t  eq [$];
   string rq [$];
   logic [15:0] fq [$];

   // memory model with fixed fill latency
   int fill_cnt = 0;
   logic [15:0] fill_addr = '0;
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (fill_cnt == 1) begin
         mem_rvalid <= 1'b1;
         mem_rdata  <= bus_mem.exists(int'(fill_addr)) ? bus_mem[int'(fill_addr)] : base_word(fill_addr);
      end
      if (fill_cnt > 0) fill_cnt <= fill_cnt - 1;
      if (rst_n && mem_valid) begin
         if (mem_write) begin
            bus_mem[int'(mem_addr)] = mem_wdata;
         end else begin
            fill_cnt  <= FILL_LAT;
            fill_addr <= mem_addr;
            if (fq.size() == 0) check(1'b0, "R3", "unexpected fetch", 32'(mem_addr), 32'hFFFF);
            else begin
               logic [15:0] ea;
               ea = fq.pop_front();
               check(mem_addr == ea, "R3", "fetch address", 32'(mem_addr), 32'(ea));
            end
         end
      end
   end

   // monitor: scoreboard comparison
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (eq.size() == 0) check(1'b0, "R2", "response with empty queue", 32'(rsp_rdata), 0);
         else begin
            exp_t e;
            string r;
            e = eq.pop_front();
            r = rq.pop_front();
            check(rsp_hit == e.hit, r, "hit flag", 32'(rsp_hit), 32'(e.hit));
            check(int'(rsp_probes) == e.probes, r, "probe count", 32'(rsp_probes), 32'(e.probes));
            check(rsp_rdata == e.data, r, "data", rsp_rdata, e.data);
            if (e.lat > 0)
               check(cyc - e.acc == e.lat, r, "latency", 32'(cyc - e.acc), 32'(e.lat));
         end
      end
   end

   task automatic access(input bit w, input logic [15:0] a, input logic [31:0] d, input string req);
      exp_t e;
      int set, hit_i, idx;
      logic [12:0] tag;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      set = int'(a[2:0]);
      tag = a[15:3];
      hit_i = -1;
      for (int i = PROBES - 1; i >= 0; i--)
         if (mv[i*SETS+set] && mt[i*SETS+set] == tag) hit_i = i;
      if (w) begin
         ref_mem[int'(a)] = d;
         e.data = d;
         if (hit_i >= 0) begin
            md[hit_i*SETS+set] = d;
            e.hit = 1; e.probes = hit_i + 1; e.lat = hit_i + 1;
         end else begin
            e.hit = 0; e.probes = PROBES; e.lat = PROBES;
         end
      end else if (hit_i >= 0) begin
         e.hit = 1; e.probes = hit_i + 1; e.lat = hit_i + 1;
         e.data = md[hit_i*SETS+set];
      end else begin
         int v;
         v = -1;
         for (int i = PROBES - 1; i >= 0; i--) if (!mv[i*SETS+set]) v = i;
         if (v < 0) begin
            v = rr[set];
            rr[set] = (rr[set] + 1) % PROBES;
         end
         idx = v*SETS + set;
         mv[idx] = 1'b1;
         mt[idx] = tag;
         md[idx] = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : base_word(a);
         e.hit = 0; e.probes = PROBES; e.lat = 0; e.data = md[idx];
         fq.push_back(a);
      end
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      e.acc = cyc;
      eq.push_back(e);
      rq.push_back(req);
      check(req_ready == 1'b0, "R8", "ready after accept", 32'(req_ready), 0);
   endtask

   task automatic drain();
      do @(negedge clk); while (eq.size() != 0 || !req_ready);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < LINES; i++) begin mv[i] = 0; mt[i] = '0; md[i] = '0; end
      for (int s = 0; s < SETS; s++) rr[s] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check(req_ready == 1'b1, "R9", "ready after reset", 32'(req_ready), 1);
      check(rsp_valid == 1'b0, "R9", "no response after reset", 32'(rsp_valid), 0);
      check(mem_valid == 1'b0, "R9", "no memory command after reset", 32'(mem_valid), 0);

      // fill one group slot by slot (R3, R4) and read back (R1, R2)
      access(0, 16'h0003, 0, "R3");
      access(0, 16'h0003, 0, "R2");
      access(0, 16'h000B, 0, "R4");
      access(0, 16'h000B, 0, "R1");
      access(0, 16'h0013, 0, "R4");
      access(0, 16'h001B, 0, "R4");
      access(0, 16'h001B, 0, "R2");
      access(0, 16'h0013, 0, "R2");
      // other group unaffected (R1)
      access(0, 16'h0005, 0, "R1");
      access(0, 16'h0005, 0, "R1");
      // full group: round robin (R5)
      access(0, 16'h0103, 0, "R5");
      access(0, 16'h0103, 0, "R5");
      access(0, 16'h0003, 0, "R5");
      access(0, 16'h000B, 0, "R5");
      access(0, 16'h0003, 0, "R5");
      // tag holds all upper bits (R10)
      access(0, 16'h8003, 0, "R10");
      access(0, 16'h0003, 0, "R10");
      // write hit and write-through (R6)
      access(1, 16'h001B, 32'hDEAD_BEEF, "R6");
      access(0, 16'h001B, 0, "R6");
      access(1, 16'h0005, 32'h1234_5678, "R6");
      // write miss, no allocate (R7)
      access(1, 16'h0207, 32'hCAFE_F00D, "R7");
      access(0, 16'h0207, 0, "R7");
      access(0, 16'h0207, 0, "R7");
      drain();
      // mixed sweep over a few groups
      for (int n = 0; n < 400; n++) begin
         logic [15:0] a;
         a = {11'($urandom_range(0, 9)), 2'b00, 3'($urandom_range(0, 2))};
         if ($urandom_range(0, 9) < 3) access(1, a, $urandom, "R6");
         else access(0, a, 0, "R2");
      end
      drain();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule